// File: doc/BRIEF.md
# Packed FP64 Alternating Add/Subtract Unit

This unit takes two vectors of IEEE-754 binary64 lanes and returns one vector in which every even-numbered lane holds the first operand minus the second and every odd-numbered lane holds the first operand plus the second. Results use round-to-nearest, ties-to-even. NaNs, infinities, signed zeros and subnormal values are all handled. Subnormal inputs are not flushed to zero.

A two-bit mode input sets how much of the vector is computed and what happens above bit 127. In the first narrow mode, the first operand also stands for the old destination, so its upper bits pass through unchanged. In the second narrow mode, the upper bits are written as zero. The wide modes compute all four lanes.

One register stage sits between the inputs and the outputs. A valid strobe loads the register. Five exception flags are reported, each ORed over the lanes the mode activates.

Top module: `pk_addsub_alt`

## Requirements
- R1: With valid_i high at a rising edge, res_o, flags_o and valid_o show that operation after the edge. Lane 0 and lane 2 compute A-B, and lane 1 and lane 3 compute A+B. Reset clears res_o, flags_o and valid_o.
- R2: Finite results are rounded to nearest, ties to even, and match binary64 arithmetic bit for bit.
- R3: With mode_i=0, res_o[255:128] equals src_a_i[255:128].
- R4: With mode_i=1, res_o[255:128] is zero.
- R5: With mode_i=2 or mode_i=3, all four lanes are computed.
- R6: The flag bits are: flags_o[0] invalid, [1] denormal operand, [2] overflow, [3] underflow, [4] inexact. Each flag is the OR over active lanes only, which are lanes 0 and 1 in modes 0 and 1.
- R7: If a lane has a NaN operand, its result is that NaN made quiet by setting bit 51. The A operand wins over B. A signalling NaN (bit 51 clear) raises invalid.
- R8: Infinities of opposite effective sign give 64'hFFF8_0000_0000_0000 and raise invalid. In every other case an infinity passes through with its effective sign.
- R9: Subnormal operands take part at their exact value and raise denormal. Subnormal results are produced exactly.
- R10: A result beyond the largest finite value becomes infinity and raises both overflow and inexact.
- R11: An exact zero from operands of opposite effective sign is +0. Adding two zeros of the same effective sign keeps that sign.
- R12: Inexact is raised when rounding discards nonzero bits. Underflow is raised only for a tiny result that is also inexact, so an exact subnormal result does not raise it.
- R13: While valid_i is low, res_o and flags_o hold and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 2 | 0 narrow-keep, 1 narrow-clear, 2/3 wide |
| src_a_i | input | 256 | First operand and old destination |
| src_b_i | input | 256 | Second operand |
| res_o | output | 256 | Registered result vector |
| flags_o | output | 5 | Registered exception flags |
| valid_o | output | 1 | Result strobe |

## Verification
On every cycle the assertions check several properties: the one-cycle latency of the strobe, that the outputs hold while idle, that the upper half is kept or cleared in the narrow modes, that clashing infinities in lane 0 give the default NaN, and that overflow always comes with inexact. Rounding ties, NaN priority and quieting, exact subnormal sums, zero signs, and the masking of flags from inactive lanes need particular operand values. Only the directed and random scenarios of the bench can show these, checked against binary64 arithmetic computed in the bench.

// File: rtl/pk_addsub_pkg.sv
package pk_addsub_pkg;
  localparam int unsigned FP_W   = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned MAN_W  = 52;
  localparam int unsigned FLAG_W = 5;
  localparam logic [FP_W-1:0] QNAN_DEFAULT = 64'hFFF8_0000_0000_0000;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'd0,
    MODE_CLEAR = 2'd1,
    MODE_WIDE  = 2'd2,
    MODE_WIDE2 = 2'd3
  } mode_e;

  // bit 0 is invalid, bit 4 is inexact
  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fp_flags_t;
endpackage

// File: rtl/fp64_align.sv
module fp64_align (
  input  logic [10:0] exp_big_i,
  input  logic [10:0] exp_small_i,
  input  logic [52:0] man_small_i,
  output logic [55:0] man_o
);
  logic [10:0] diff;
  logic [5:0]  shamt;
  logic [55:0] ext, sh, lost;

  assign diff  = exp_big_i - exp_small_i;
  assign shamt = (diff > 11'd56) ? 6'd57 : diff[5:0];
  assign ext   = {man_small_i, 3'b000};
  assign sh    = ext >> shamt;
  assign lost  = ext & ~({56{1'b1}} << shamt);
  // guard, round, sticky in the low three bits
  assign man_o = {sh[55:1], sh[0] | (|lost)};
endmodule

// File: rtl/fp64_norm_round.sv
module fp64_norm_round (
  input  logic [56:0] sum_i,
  input  logic [10:0] exp_i,
  input  logic        sign_i,
  output logic [63:0] res_o,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        inx_o
);
  logic [55:0] pre, norm;
  logic [12:0] e1, e2, e3, max_sh, shift;
  logic [5:0]  lz;
  logic [53:0] mr;
  logic [52:0] man;
  logic        rup, tiny;

  always_comb begin
    if (sum_i[56]) begin
      pre = {sum_i[56:2], sum_i[1] | sum_i[0]};
      e1  = {2'b00, exp_i} + 13'd1;
    end else begin
      pre = sum_i[55:0];
      e1  = {2'b00, exp_i};
    end
    lz = 6'd56;
    for (int i = 0; i < 56; i++) begin
      if (pre[i]) lz = 6'(55 - i);
    end
    // stop at exponent 1 so small results stay subnormal
    max_sh = e1 - 13'd1;
    shift  = ({7'b0, lz} < max_sh) ? {7'b0, lz} : max_sh;
    norm   = pre << shift;
    e2     = e1 - shift;
    tiny   = ~norm[55];
    inx_o  = |norm[2:0];
    rup    = norm[2] & (norm[1] | norm[0] | norm[3]);
    mr     = {1'b0, norm[55:3]} + {53'b0, rup};
    if (mr[53]) begin
      man = mr[53:1];
      e3  = e2 + 13'd1;
    end else begin
      man = mr[52:0];
      e3  = e2;
    end
    ovf_o = e3 >= 13'd2047;
    unf_o = tiny & inx_o;
    if (ovf_o) begin
      res_o = {sign_i, 11'h7FF, 52'b0};
      inx_o = 1'b1;
    end else begin
      res_o = {sign_i, man[52] ? e3[10:0] : 11'd0, man[51:0]};
    end
  end
endmodule

// File: rtl/fp64_lane_addsub.sv
module fp64_lane_addsub
  import pk_addsub_pkg::*;
(
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic        sub_i,
  output logic [63:0] res_o,
  output fp_flags_t   flags_o
);
  logic        sa, sb, sb_eff, eff_sub, a_ge;
  logic [10:0] ea, eb, ea_x, eb_x, big_exp, small_exp;
  logic [51:0] ma, mb;
  logic [52:0] big_man, small_man;
  logic        big_sign, sign_res;
  logic        a_nan, b_nan, a_inf, b_inf, a_snan, b_snan, a_den, b_den;
  logic [55:0] small_al;
  logic [56:0] sum;
  logic [63:0] norm_res;
  logic        ovf, unf, inx;

  assign {sa, ea, ma} = a_i;
  assign {sb, eb, mb} = b_i;
  assign sb_eff  = sb ^ sub_i;
  assign eff_sub = sa ^ sb_eff;

  assign a_nan  = (&ea) & (|ma);
  assign b_nan  = (&eb) & (|mb);
  assign a_inf  = (&ea) & ~(|ma);
  assign b_inf  = (&eb) & ~(|mb);
  assign a_snan = a_nan & ~ma[51];
  assign b_snan = b_nan & ~mb[51];
  assign a_den  = ~(|ea) & (|ma);
  assign b_den  = ~(|eb) & (|mb);

  assign ea_x = (ea == 11'd0) ? 11'd1 : ea;
  assign eb_x = (eb == 11'd0) ? 11'd1 : eb;
  assign a_ge = {ea, ma} >= {eb, mb};

  assign big_exp   = a_ge ? ea_x : eb_x;
  assign small_exp = a_ge ? eb_x : ea_x;
  assign big_man   = a_ge ? {|ea, ma} : {|eb, mb};
  assign small_man = a_ge ? {|eb, mb} : {|ea, ma};
  assign big_sign  = a_ge ? sa : sb_eff;

  fp64_align u_align (
    .exp_big_i  (big_exp),
    .exp_small_i(small_exp),
    .man_small_i(small_man),
    .man_o      (small_al)
  );

  assign sum = eff_sub ? ({1'b0, big_man, 3'b000} - {1'b0, small_al})
                       : ({1'b0, big_man, 3'b000} + {1'b0, small_al});
  assign sign_res = (sum == 57'd0) ? (eff_sub ? 1'b0 : sa) : big_sign;

  fp64_norm_round u_round (
    .sum_i (sum),
    .exp_i (big_exp),
    .sign_i(sign_res),
    .res_o (norm_res),
    .ovf_o (ovf),
    .unf_o (unf),
    .inx_o (inx)
  );

  always_comb begin
    res_o            = norm_res;
    flags_o          = '0;
    flags_o.denormal = a_den | b_den;
    if (a_nan || b_nan) begin
      res_o = a_nan ? {a_i[63:52], 1'b1, a_i[50:0]} : {b_i[63:52], 1'b1, b_i[50:0]};
      flags_o.invalid = a_snan | b_snan;
    end else if (a_inf && b_inf && eff_sub) begin
      res_o           = QNAN_DEFAULT;
      flags_o.invalid = 1'b1;
    end else if (a_inf) begin
      res_o = {sa, 11'h7FF, 52'b0};
    end else if (b_inf) begin
      res_o = {sb_eff, 11'h7FF, 52'b0};
    end else begin
      flags_o.overflow  = ovf;
      flags_o.underflow = unf;
      flags_o.inexact   = inx;
    end
  end
endmodule

// File: rtl/pk_addsub_alt.sv
module pk_addsub_alt
  import pk_addsub_pkg::*;
#(
  parameter int unsigned VEC_W    = 256,
  parameter int unsigned LEGACY_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  output logic [VEC_W-1:0]  res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              valid_o
);
  localparam int unsigned LANES      = VEC_W / FP_W;
  localparam int unsigned BASE_LANES = LEGACY_W / FP_W;

  logic [FP_W-1:0]   lane_res   [LANES];
  logic [FLAG_W-1:0] lane_flags [LANES];
  logic [VEC_W-1:0]  res_d;
  logic [FLAG_W-1:0] flags_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp64_lane_addsub u_lane (
      .a_i    (src_a_i[g*FP_W +: FP_W]),
      .b_i    (src_b_i[g*FP_W +: FP_W]),
      .sub_i  ((g % 2) == 0),
      .res_o  (lane_res[g]),
      .flags_o(lane_flags[g])
    );
  end

  always_comb begin
    res_d   = '0;
    flags_d = '0;
    for (int l = 0; l < LANES; l++) begin
      if (mode_i[1] || (l < BASE_LANES)) begin
        res_d[l*FP_W +: FP_W] = lane_res[l];
        flags_d               = flags_d | lane_flags[l];
      end else if (mode_e'(mode_i) == MODE_KEEP) begin
        res_d[l*FP_W +: FP_W] = src_a_i[l*FP_W +: FP_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      flags_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        flags_o <= flags_d;
      end
    end
  end
endmodule

// File: rtl/pk_addsub_alt_chk.sv
module pk_addsub_alt_chk #(
  parameter int unsigned VEC_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic [VEC_W-1:0] src_a_i,
  input logic [VEC_W-1:0] src_b_i,
  input logic [VEC_W-1:0] res_o,
  input logic [4:0]       flags_o,
  input logic             valid_o
);
  logic inf_clash0;
  assign inf_clash0 = (src_a_i[62:0] == 63'h7FF0_0000_0000_0000) &&
                      (src_b_i[62:0] == 63'h7FF0_0000_0000_0000) &&
                      (src_a_i[63] == src_b_i[63]);

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R13
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(flags_o))); // R13
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0) |=> res_o[VEC_W-1:128] == $past(src_a_i[VEC_W-1:128])); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1) |=> res_o[VEC_W-1:128] == '0); // R4
  AST_INF_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inf_clash0) |=> (res_o[63:0] == 64'hFFF8_0000_0000_0000 && flags_o[0])); // R8
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[2]) |-> flags_o[4]); // R10
endmodule

bind pk_addsub_alt pk_addsub_alt_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .mode_i (mode_i),
  .src_a_i(src_a_i),
  .src_b_i(src_b_i),
  .res_o  (res_o),
  .flags_o(flags_o),
  .valid_o(valid_o)
);

// File: tb/pk_addsub_alt_tb.sv
module pk_addsub_alt_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [255:0] src_a_i = '0;
  logic [255:0] src_b_i = '0;
  logic [255:0] res_o;
  logic [4:0]   flags_o;
  logic         valid_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pk_addsub_alt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o),
    .flags_o(flags_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; src_a_i = a; src_b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // exact rounding error of x+y (two-sum)
  function automatic logic lost_bits(input real x, input real y);
    real s, bb, err;
    s   = x + y;
    bb  = s - x;
    err = (x - (s - bb)) + (y - bb);
    return err != 0.0;
  endfunction

  task automatic model(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b,
                       output logic [255:0] r, output logic [4:0] f);
    r = '0; f = '0;
    for (int l = 0; l < 4; l++) begin
      if (m[1] || l < 2) begin
        real x, y;
        x = $bitstoreal(a[l*64 +: 64]);
        y = $bitstoreal(b[l*64 +: 64]);
        if (l % 2 == 0) y = -y;
        r[l*64 +: 64] = $realtobits(x + y);
        if (lost_bits(x, y)) f[4] = 1'b1;
      end else if (m == 2'd0) begin
        r[l*64 +: 64] = a[l*64 +: 64];
      end
    end
  endtask

  function automatic logic [63:0] rnd_norm();
    logic [10:0] e;
    logic [51:0] mt;
    e  = 11'(900 + ($urandom % 200));
    mt = {$urandom, $urandom} & {52{1'b1}};
    return {1'($urandom), e, mt};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] a, b, er;
    logic [4:0]   ef;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 reset res", res_o, '0);
    chk("R1 reset flags/valid", {250'b0, flags_o, valid_o}, '0);
    rst_ni = 1'b1;

    // R8: +inf - +inf (lane0), +inf + -inf (lane1)
    drive(2'd2, {192'b0, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000},
                {192'b0, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000});
    chk("R8 clash result", res_o, {128'b0, 64'hFFF8_0000_0000_0000, 64'hFFF8_0000_0000_0000});
    chk("R8 invalid", {251'b0, flags_o}, 256'h01);
    chk("R1 valid_o", {255'b0, valid_o}, 256'h1);

    // R8: inf passes with effective sign (lane0: 1 - +inf = -inf)
    drive(2'd1, {128'b0, 64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000},
                {128'b0, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000});
    chk("R8 inf pass", res_o, {128'b0, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000});

    // R7: sNaN in A lane0, qNaN in B lane1, A NaN wins in lane2
    drive(2'd2, {64'h0, 64'h7FF0_0000_0000_0009, 64'h4000_0000_0000_0000, 64'h7FF0_0000_0000_0001},
                {64'h0, 64'hFFF8_0000_0000_0007, 64'hFFF8_0000_0000_0005, 64'h3FF0_0000_0000_0000});
    chk("R7 nan result", res_o, {64'h0, 64'h7FF8_0000_0000_0009, 64'hFFF8_0000_0000_0005, 64'h7FF8_0000_0000_0001});
    chk("R7 invalid", {251'b0, flags_o}, 256'h01);

    // R9/R12: denormal sum (lane1) and exact subnormal difference (lane0)
    drive(2'd1, {128'b0, 64'h0000_0000_0000_0001, 64'h0010_0000_0000_0001},
                {128'b0, 64'h0000_0000_0000_0001, 64'h0010_0000_0000_0000});
    chk("R9 subnormal result", res_o, {128'b0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001});
    chk("R12 denormal only, no underflow", {251'b0, flags_o}, 256'h02);

    // R10: max + max overflows (lane1), max - max = +0 (lane0)
    drive(2'd1, {128'b0, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF},
                {128'b0, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF});
    chk("R10 overflow result", res_o, {128'b0, 64'h7FF0_0000_0000_0000, 64'h0});
    chk("R10 overflow flags", {251'b0, flags_o}, 256'h14);

    // R11: zero signs
    drive(2'd3, {64'h3FF0_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 64'hC008_0000_0000_0000},
                {64'hBFF0_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 64'hC008_0000_0000_0000});
    chk("R11 zero signs", res_o, {64'h0, 64'h0, 64'h8000_0000_0000_0000, 64'h0});
    chk("R11 no flags", {251'b0, flags_o}, 256'h0);

    // R2: tie to even (lane1 stays), tie rounds up to even (lane3)
    drive(2'd2, {64'h3FF0_0000_0000_0001, 64'h0, 64'h3FF0_0000_0000_0000, 64'h0},
                {64'h3CA0_0000_0000_0000, 64'h0, 64'h3CA0_0000_0000_0000, 64'h0});
    chk("R2 ties", res_o, {64'h3FF0_0000_0000_0002, 64'h0, 64'h3FF0_0000_0000_0000, 64'h0});
    chk("R12 inexact", {251'b0, flags_o}, 256'h10);

    // R6/R3: sNaN in inactive lane2 under mode 0 must not raise invalid
    a = {64'h1234_5678_9ABC_DEF0, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000};
    b = {64'h0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000};
    drive(2'd0, a, b);
    chk("R3 keep upper", res_o, {a[255:128], 64'h4000_0000_0000_0000, 64'h0});
    chk("R6 inactive lane flags masked", {251'b0, flags_o}, 256'h0);

    // R13: idle cycle with new inputs leaves outputs unchanged
    @(negedge clk_i);
    mode_i = 2'd2; src_a_i = ~a; src_b_i = ~b;
    @(negedge clk_i);
    chk("R13 hold res", res_o, {a[255:128], 64'h4000_0000_0000_0000, 64'h0});
    chk("R13 hold flags/valid", {250'b0, flags_o, valid_o}, 256'h0);

    // R1/R2/R4/R5: random normal operands across all modes
    for (int n = 0; n < 200; n++) begin
      logic [1:0] m;
      m = 2'(n % 4);
      a = {rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()};
      b = {rnd_norm(), rnd_norm(), rnd_norm(), rnd_norm()};
      if (n % 17 == 0) b = a;
      model(m, a, b, er, ef);
      drive(m, a, b);
      case (m)
        2'd0:    chk("R3 R2 random keep", res_o, er);
        2'd1:    chk("R4 R2 random clear", res_o, er);
        default: chk("R5 R1 random wide", res_o, er);
      endcase
      chk("R6 R12 random flags", {251'b0, flags_o}, {251'b0, ef});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule